// File: doc/BRIEF.md
# Banked Data-Memory Address Decoder

This block sits between the data-access stage of a small 8-bit controller core and its register storage. Each request carries either a 7-bit direct address with a single bank-select bit placed above it, or a full 8-bit address from the indirect path. The block forms the 8-bit banked address and sorts the access into one of three targets. Special-function register locations are passed out on a select strobe with a 5-bit local offset. General-purpose locations go to an internal synchronous RAM. Any other location is a hole.

The RAM holds only the bytes that exist and nothing more. Two separate address ranges are packed into one contiguous physical index. A 16-byte window at the top of the upper bank is folded onto the top 16 bytes of the lower bank, so both addresses reach the same storage. Holes read as zero, and writes to them are dropped. A parameter selects either the full map or a reduced map. The reduced map keeps general-purpose RAM only in the upper half of the lower bank, and it keeps the folded window.

Top module: `banked_regfile_dec`

## Requirements
- R1: With `addr_mode`=0 the banked address is {`bank_sel`, `dir_addr`}. With `addr_mode`=1 it is `ind_addr`, where bit 7 selects the bank.
- R2: For banked addresses 00h-1Fh and 80h-9Fh, `sfr_sel` is high in the same cycle as `req_valid`. In that cycle `sfr_ofs` equals address bits 4:0, `sfr_bank` equals address bit 7, and `sfr_we` equals `req_write`. `sfr_sel` and `sfr_we` are low whenever no request is made to that space.
- R3: With FULL_MAP=1, locations 20h-7Fh store bytes. A read returns the stored byte on `rd_data`, with `rd_valid` high, exactly one clock after the request cycle.
- R4: Locations A0h-BFh (FULL_MAP=1) hold storage that is separate from every lower-bank location.
- R5: A write to F0h+n (n=0..15) is visible when reading 70h+n, and a write to 70h+n is visible when reading F0h+n. This holds in both map configurations.
- R6: Unimplemented locations read 00h. These are C0h-EFh in both configurations, plus 20h-3Fh and A0h-BFh when FULL_MAP=0.
- R7: A write to an unimplemented location changes no stored byte.
- R8: After reset, and in every cycle that does not follow a read request, `rd_valid` is 0 and `rd_data` is 00h.
- R9: When a read is followed directly by a write to the same byte, the read returns the byte's value from before the write.
- R10: A read from the special-function space returns 00h on `rd_data`, with `rd_valid` high, one cycle later. That data is supplied by the register block itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| addr_mode | input | 1 | 0 = direct (bank bit + 7-bit), 1 = full 8-bit address |
| bank_sel | input | 1 | Bank select bit for direct mode |
| dir_addr | input | 7 | Direct address from the instruction |
| ind_addr | input | 8 | Full banked address for indirect access |
| wr_data | input | DW | Write data (RAM and SFR port) |
| rd_data | output | DW | Read data, one cycle after a read request |
| rd_valid | output | 1 | High one cycle after a read request |
| sfr_sel | output | 1 | Access targets special-function space |
| sfr_we | output | 1 | SFR access is a write |
| sfr_bank | output | 1 | Bank of the SFR access |
| sfr_ofs | output | 5 | Offset within the SFR space |

## Verification
The registered read return and a new request share a cycle whenever accesses run back to back. The case that matters is a read followed at once by a write to the same byte. The bench drives that pair and samples `rd_data` during the write cycle, before the edge that commits the write. It expects the old byte and then confirms the new byte with a later read. The same overlap is exercised when an SFR strobe is raised while a previous RAM read is still returning. Here the bench checks that both outputs carry their own values.

// File: rtl/banked_regfile_dec.sv
module banked_regfile_dec #(
  parameter bit FULL_MAP = 1'b1,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          addr_mode,
  input  logic          bank_sel,
  input  logic [6:0]    dir_addr,
  input  logic [7:0]    ind_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          sfr_sel,
  output logic          sfr_we,
  output logic          sfr_bank,
  output logic [4:0]    sfr_ofs
);
  localparam int RAM_DEPTH = FULL_MAP ? 128 : 64;
  localparam int IDX_W     = $clog2(RAM_DEPTH);
  localparam logic [7:0] LO_BASE  = FULL_MAP ? 8'h20 : 8'h40;
  localparam logic [7:0] HI_INDEX = 8'h60;
  localparam logic [7:0] ALIAS_IX = 8'h70 - LO_BASE;

  logic [7:0]       eff;
  logic             is_sfr;
  logic             ram_hit;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    mem [RAM_DEPTH];

  assign eff    = addr_mode ? ind_addr : {bank_sel, dir_addr};
  assign is_sfr = (eff[6:5] == 2'b00);

  always_comb begin
    ram_hit = 1'b0;
    idx     = '0;
    if (eff[7:4] == 4'hF) begin
      ram_hit = 1'b1;
      idx     = IDX_W'(ALIAS_IX + {4'h0, eff[3:0]});
    end else if (!eff[7] && (eff >= LO_BASE)) begin
      ram_hit = 1'b1;
      idx     = IDX_W'(eff - LO_BASE);
    end else if (FULL_MAP && eff[7] && eff[6:5] == 2'b01) begin
      ram_hit = 1'b1;
      idx     = IDX_W'(HI_INDEX + {3'b000, eff[4:0]});
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid && req_write && ram_hit)
      mem[idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      rd_data  <= (req_valid && !req_write && ram_hit) ? mem[idx] : '0;
    end
  end

  assign sfr_sel  = req_valid && is_sfr;
  assign sfr_we   = sfr_sel && req_write;
  assign sfr_bank = eff[7];
  assign sfr_ofs  = eff[4:0];
endmodule

// File: rtl/banked_regfile_dec_chk.sv
module banked_regfile_dec_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          sfr_sel,
  input logic          sfr_we
);
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_write) |=> rd_valid); // R3
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n) !(req_valid && !req_write) |=> !rd_valid); // R8
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !rd_valid |-> rd_data == '0); // R8
  AST_SFR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (sfr_sel && !req_write) |=> rd_data == '0); // R10
  AST_SFR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |-> !sfr_sel); // R2
  AST_SFR_WE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n) sfr_we |-> (sfr_sel && req_write)); // R2
endmodule

bind banked_regfile_dec banked_regfile_dec_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rd_data(rd_data), .rd_valid(rd_valid), .sfr_sel(sfr_sel), .sfr_we(sfr_we)
);

// File: tb/sim_banked_regfile_dec.sv
module sim_banked_regfile_dec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, addr_mode = 1'b1, bank_sel = 1'b0;
  logic [6:0] dir_addr = '0;
  logic [7:0] ind_addr = '0, wr_data = '0;
  logic [7:0] rd0, rd1, so0, so1;
  logic rv0, rv1, ss0, ss1, sw0, sw1, sb0, sb1;
  logic [4:0] ofs0, ofs1;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] m_full [256];
  logic [7:0] m_red  [256];

  always #5 clk = ~clk;

  banked_regfile_dec #(.FULL_MAP(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .addr_mode(addr_mode), .bank_sel(bank_sel), .dir_addr(dir_addr), .ind_addr(ind_addr),
    .wr_data(wr_data), .rd_data(rd0), .rd_valid(rv0), .sfr_sel(ss0), .sfr_we(sw0),
    .sfr_bank(sb0), .sfr_ofs(ofs0));

  banked_regfile_dec #(.FULL_MAP(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .addr_mode(addr_mode), .bank_sel(bank_sel), .dir_addr(dir_addr), .ind_addr(ind_addr),
    .wr_data(wr_data), .rd_data(rd1), .rd_valid(rv1), .sfr_sel(ss1), .sfr_we(sw1),
    .sfr_bank(sb1), .sfr_ofs(ofs1));

  assign so0 = {3'b000, ofs0};
  assign so1 = {3'b000, ofs1};

  function automatic bit hit_full(input logic [7:0] a);
    return (a >= 8'h20 && a <= 8'h7F) || (a >= 8'hA0 && a <= 8'hBF) || (a >= 8'hF0);
  endfunction
  function automatic bit hit_red(input logic [7:0] a);
    return (a >= 8'h40 && a <= 8'h7F) || (a >= 8'hF0);
  endfunction
  function automatic logic [7:0] canon(input logic [7:0] a);
    return (a >= 8'hF0) ? a - 8'h80 : a;
  endfunction
  function automatic bit in_sfr(input logic [7:0] a);
    return a[6:5] == 2'b00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; addr_mode = 1'b1; ind_addr = a; wr_data = d;
    @(posedge clk); #1;
    if (we && hit_full(a)) m_full[canon(a)] = d;
    if (we && hit_red(a))  m_red[canon(a)]  = d;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  localparam logic [24:0] VEC [13] = '{
    {1'b1, 8'h20, 8'h11, 8'h00}, {1'b1, 8'hA0, 8'h22, 8'h00},
    {1'b1, 8'h7F, 8'h33, 8'h00}, {1'b1, 8'hBF, 8'h44, 8'h00},
    {1'b1, 8'hF3, 8'h55, 8'h00}, {1'b0, 8'h20, 8'h00, 8'h11},
    {1'b0, 8'hA0, 8'h00, 8'h22}, {1'b0, 8'h7F, 8'h00, 8'h33},
    {1'b0, 8'hBF, 8'h00, 8'h44}, {1'b0, 8'h73, 8'h00, 8'h55},
    {1'b1, 8'hD0, 8'h66, 8'h00}, {1'b0, 8'hD0, 8'h00, 8'h00},
    {1'b0, 8'h05, 8'h00, 8'h00}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m_full[i] = 8'h00; m_red[i] = 8'h00; end
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset rd_valid", rv0, 0);
    chk("R8 reset rd_data", rd0, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R8 idle rd_data", rd0, 0);
    chk("R2 idle sfr_sel", ss0, 0);

    for (int a = 0; a < 256; a++)
      if (!in_sfr(8'(a))) acc(1'b1, 8'(a), 8'(a) ^ 8'hA5);

    foreach (VEC[i]) begin
      acc(VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
      if (!VEC[i][24]) begin
        chk("R3/R4/R5/R6/R10 table rd_valid", rv0, 1);
        chk("R3/R4/R5/R6/R10 table rd_data", rd0, VEC[i][7:0]);
      end
    end
    idle();

    // R1: direct mode write to bank 1, read back through the full address
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; addr_mode = 1'b0; bank_sel = 1'b1;
    dir_addr = 7'h21; wr_data = 8'h99;
    @(posedge clk); #1;
    m_full[8'hA1] = 8'h99;
    acc(1'b0, 8'hA1, 8'h00);
    chk("R1 direct-mode bank1 write", rd0, 8'h99);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; addr_mode = 1'b0; bank_sel = 1'b0; dir_addr = 7'h21;
    @(posedge clk); #1;
    chk("R1 direct-mode bank0 distinct", rd0, m_full[8'h21]);

    // R2: SFR strobe in the request cycle; overlaps return of the prior RAM read
    acc(1'b0, 8'h30, 8'h00);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; addr_mode = 1'b1; ind_addr = 8'h85; #1;
    chk("R2 sfr_sel", ss0, 1);
    chk("R2 sfr_ofs", so0, 8'h05);
    chk("R2 sfr_bank", sb0, 1);
    chk("R2 sfr_we read", sw0, 0);
    chk("R2 ram read returning alongside sfr", rd0, m_full[8'h30]);
    @(posedge clk); #1;
    chk("R10 sfr read data", rd0, 0);
    chk("R10 sfr read valid", rv0, 1);
    @(negedge clk);
    req_write = 1'b1; addr_mode = 1'b0; bank_sel = 1'b0; dir_addr = 7'h1F; wr_data = 8'h3C; #1;
    chk("R2 sfr_we write", sw0, 1);
    chk("R2 sfr_ofs direct", so0, 8'h1F);
    chk("R2 sfr_bank direct", sb0, 0);
    chk("R2 reduced map sfr_sel", ss1, 1);
    @(posedge clk); #1;
    acc(1'b0, 8'h40, 8'h00);
    chk("R2 no ram write from sfr", rd0, m_full[8'h40]);
    acc(1'b0, 8'h20, 8'h00);
    chk("R2 sfr_sel low for gpr", ss0, 0);

    // R9: read then write same byte back to back
    acc(1'b0, 8'h55, 8'h00);
    chk("R9 read before write", rd0, m_full[8'h55]);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; addr_mode = 1'b1; ind_addr = 8'h55; wr_data = 8'hE7; #1;
    chk("R9 old data during write cycle", rd0, m_full[8'h55]);
    @(posedge clk); #1;
    m_full[8'h55] = 8'hE7; m_red[8'h55] = 8'hE7;
    acc(1'b0, 8'h55, 8'h00);
    chk("R9 new data after write", rd0, 8'hE7);

    // R5: lower-bank write visible through the folded window
    acc(1'b1, 8'h7A, 8'h5A);
    acc(1'b0, 8'hFA, 8'h00);
    chk("R5 full fold", rd0, 8'h5A);
    chk("R5 reduced fold", rd1, 8'h5A);

    // R7: writes to holes
    for (int a = 8'hC0; a < 8'hF0; a++) acc(1'b1, 8'(a), 8'hFF);
    for (int a = 8'h20; a < 8'h40; a++) acc(1'b1, 8'(a), 8'hFF);
    idle();
    @(posedge clk); #1;
    chk("R8 no read, no valid", rv0, 0);

    // R3/R4/R5/R6/R7: full scan of both maps
    for (int a = 0; a < 256; a++) begin
      logic [7:0] ef, er;
      acc(1'b0, 8'(a), 8'h00);
      ef = (!in_sfr(8'(a)) && hit_full(8'(a))) ? m_full[canon(8'(a))] : 8'h00;
      er = (!in_sfr(8'(a)) && hit_red(8'(a)))  ? m_red[canon(8'(a))]  : 8'h00;
      chk($sformatf("R6/R7 full map scan %02h", a), rd0, ef);
      chk($sformatf("R6/R7 reduced map scan %02h", a), rd1, er);
    end
    idle();
    @(posedge clk); #1;
    chk("R8 final idle", rd0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule